// File: doc/BRIEF.md
# CAN Acceptance Filter Unit

This block decides, for each received CAN frame, whether the frame may be stored. It looks at the frame's identifier, its extended and remote flags, its data length code and its first two data bytes. It compares these against four code bytes and four mask bytes. A mask bit of 1 marks the matching bit position as "don't care".

The same eight configuration bytes are read in four layouts. The layout depends on the single/dual selection and on whether the frame is standard (11-bit identifier) or extended (29-bit identifier). When the enhanced-mode enable is low, filtering is bypassed and every frame is accepted.

The decision is registered. It appears one clock after the frame strobe. The configuration inputs are expected to change only while the surrounding controller is held in its reset mode.

Top module: `can_accept_filter`

## Requirements
- R1: `acc_valid` is high exactly one cycle after a cycle with `frm_valid` high and low otherwise; `acc_hit` is low whenever `acc_valid` is low; both are low after reset.
- R2: With `cfg_enh` low, every presented frame is accepted regardless of configuration and frame content.
- R3: Single filter, extended frame (`frm_ext`=1): the bytes {code0,code1,code2,code3[7:3]} are compared with `frm_id[28:0]`, and code3[2] is compared with `frm_rtr`, under the mask bytes in the same positions. Mask bit 1 means don't care. Code byte k is `cfg_code[8k+7:8k]`; mask byte k is `cfg_mask[8k+7:8k]`.
- R4: Single filter, standard frame: code0 is compared with `frm_id[10:3]`, code1[7:5] with `frm_id[2:0]` and code1[4] with `frm_rtr`, under mask bytes 0 and 1. `frm_id[28:11]` is ignored for standard frames.
- R5: Single filter, standard frame whose identifier matches: a remote frame, or a frame with DLC 0, is accepted without any data comparison.
- R6: Single filter, standard data frame with DLC ≥ 1: `frm_data0` must match code2 under mask2. When DLC ≥ 2, `frm_data1` must also match code3 under mask3; with DLC 1 the second byte is ignored.
- R7: Dual filter, extended frame: filter A compares `frm_id[28:13]` with {code0,code1} under {mask0,mask1}. Filter B does the same with {code2,code3} under {mask2,mask3}. `frm_id[12:0]` and `frm_rtr` are ignored. The frame is accepted when either filter matches.
- R8: Dual filter, standard frame, filter A: the identifier and RTR are compared with code0/code1[7:4] under mask0/mask1[7:4]. In addition, `frm_data0` must match {code1[3:0],code3[3:0]} under {mask1[3:0],mask3[3:0]}, whatever the DLC.
- R9: Dual filter, standard frame, filter B: the identifier and RTR are compared with code2/code3[7:4] under mask2/mask3[7:4], with no data comparison. Acceptance is filter A OR filter B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame fields are valid this cycle |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_ext | input | 1 | Extended-format frame |
| frm_rtr | input | 1 | Remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| cfg_code | input | 32 | Code bytes 0..3, byte k at bits 8k+7:8k |
| cfg_mask | input | 32 | Mask bytes 0..3, byte k at bits 8k+7:8k, 1 = don't care |
| cfg_single | input | 1 | 1 selects single filter, 0 selects dual filter |
| cfg_enh | input | 1 | Filtering enable; 0 accepts every frame |
| acc_valid | output | 1 | Decision valid, one cycle after `frm_valid` |
| acc_hit | output | 1 | Frame accepted |

## Verification
The bench builds the block with its default widths: a 29-bit identifier, 8-bit configuration bytes and a 4-bit DLC. These are the only widths the layouts are defined for. With them, every layout can be reached: single and dual filtering, each with standard and extended frames, plus the bypass case.

Random masks are biased toward don't-care bits. Half of the random identifiers and first data bytes are copied from the code bytes. This makes both accepted and rejected frames common in every layout. Directed frames cover the edges: the DLC 0/1/2 boundaries, remote frames, and the low identifier bits that dual-filter extended matching ignores.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
   localparam int unsigned EXT_ID_W  = 29;
   localparam int unsigned STD_ID_W  = 11;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned DLC_W     = 4;
   localparam int unsigned CFG_BYTES = 4;
   localparam int unsigned CFG_W     = CFG_BYTES * BYTE_W;
   localparam int unsigned HALF_ID_W = 2 * BYTE_W;

   typedef struct packed {
      logic [EXT_ID_W-1:0] id;
      logic                ext;
      logic                rtr;
      logic [DLC_W-1:0]    dlc;
      logic [BYTE_W-1:0]   d0;
      logic [BYTE_W-1:0]   d1;
   } frame_t;
endpackage

// File: rtl/can_flt_single.sv
module can_flt_single
   import can_flt_pkg::*;
(
   input  frame_t           frm,
   input  logic [CFG_W-1:0] code,
   input  logic [CFG_W-1:0] mask,
   output logic             hit
);
   localparam int unsigned STD_CMP_W = STD_ID_W + 1;

   logic [BYTE_W-1:0] cb [CFG_BYTES];
   logic [BYTE_W-1:0] mb [CFG_BYTES];

   for (genvar k = 0; k < CFG_BYTES; k++) begin : g_split
      assign cb[k] = code[k*BYTE_W +: BYTE_W];
      assign mb[k] = mask[k*BYTE_W +: BYTE_W];
   end

   // extended layout: 29 id bits then rtr, two unused low bits
   logic [CFG_W-1:0] ext_obs, ext_exp, ext_dc;
   logic             ext_hit;
   assign ext_obs = {frm.id, frm.rtr, 2'b00};
   assign ext_exp = {cb[0], cb[1], cb[2], cb[3]};
   assign ext_dc  = {mb[0], mb[1], mb[2], mb[3]} | {{(CFG_W-2){1'b0}}, 2'b11};
   assign ext_hit = ((ext_obs ^ ext_exp) & ~ext_dc) == '0;

   // standard layout: 11 id bits then rtr
   logic [STD_CMP_W-1:0] std_obs, std_exp, std_dc;
   logic                 id_ok, d0_ok, d1_ok, no_data, std_hit;
   assign std_obs = {frm.id[STD_ID_W-1:0], frm.rtr};
   assign std_exp = {cb[0], cb[1][BYTE_W-1 -: 4]};
   assign std_dc  = {mb[0], mb[1][BYTE_W-1 -: 4]};
   assign id_ok   = ((std_obs ^ std_exp) & ~std_dc) == '0;
   assign d0_ok   = ((frm.d0 ^ cb[2]) & ~mb[2]) == '0;
   assign d1_ok   = ((frm.d1 ^ cb[3]) & ~mb[3]) == '0;
   assign no_data = frm.rtr || (frm.dlc == '0);

   always_comb begin
      std_hit = 1'b0;
      if (id_ok) begin
         if (no_data)
            std_hit = 1'b1;
         else if (frm.dlc < DLC_W'(2))
            std_hit = d0_ok;
         else
            std_hit = d0_ok && d1_ok;
      end
   end

   assign hit = frm.ext ? ext_hit : std_hit;
endmodule

// File: rtl/can_flt_dual.sv
module can_flt_dual
   import can_flt_pkg::*;
#(
   parameter int unsigned NBANK = 2
)(
   input  frame_t           frm,
   input  logic [CFG_W-1:0] code,
   input  logic [CFG_W-1:0] mask,
   output logic             hit
);
   localparam int unsigned STD_CMP_W = STD_ID_W + 1;
   localparam int unsigned NIB_W     = BYTE_W / 2;

   if (NBANK * 2 != CFG_BYTES) begin : g_bad_bank
      $error("can_flt_dual: NBANK must use the code bytes in pairs");
   end

   logic [BYTE_W-1:0] cb [CFG_BYTES];
   logic [BYTE_W-1:0] mb [CFG_BYTES];
   logic [NBANK-1:0]  bank_hit;

   for (genvar k = 0; k < CFG_BYTES; k++) begin : g_split
      assign cb[k] = code[k*BYTE_W +: BYTE_W];
      assign mb[k] = mask[k*BYTE_W +: BYTE_W];
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic [HALF_ID_W-1:0] ext_exp, ext_dc;
      logic [STD_CMP_W-1:0] std_exp, std_dc, std_obs;
      logic                 ext_ok, std_ok, dat_ok;

      assign ext_exp = {cb[2*g], cb[2*g+1]};
      assign ext_dc  = {mb[2*g], mb[2*g+1]};
      assign ext_ok  = ((frm.id[EXT_ID_W-1 -: HALF_ID_W] ^ ext_exp) & ~ext_dc) == '0;

      assign std_obs = {frm.id[STD_ID_W-1:0], frm.rtr};
      assign std_exp = {cb[2*g], cb[2*g+1][BYTE_W-1 -: 4]};
      assign std_dc  = {mb[2*g], mb[2*g+1][BYTE_W-1 -: 4]};
      assign std_ok  = ((std_obs ^ std_exp) & ~std_dc) == '0;

      if (g == 0) begin : g_with_data
         logic [BYTE_W-1:0] d_exp, d_dc;
         assign d_exp  = {cb[1][NIB_W-1:0], cb[3][NIB_W-1:0]};
         assign d_dc   = {mb[1][NIB_W-1:0], mb[3][NIB_W-1:0]};
         assign dat_ok = ((frm.d0 ^ d_exp) & ~d_dc) == '0;
      end else begin : g_id_only
         assign dat_ok = 1'b1;
      end

      assign bank_hit[g] = frm.ext ? ext_ok : (std_ok && dat_ok);
   end

   assign hit = |bank_hit;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import can_flt_pkg::*;
#(
   parameter int unsigned ID_W   = EXT_ID_W,
   parameter int unsigned DATA_W = BYTE_W,
   parameter int unsigned LEN_W  = DLC_W,
   parameter int unsigned CODE_W = CFG_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic [ID_W-1:0]   frm_id,
   input  logic              frm_ext,
   input  logic              frm_rtr,
   input  logic [LEN_W-1:0]  frm_dlc,
   input  logic [DATA_W-1:0] frm_data0,
   input  logic [DATA_W-1:0] frm_data1,
   input  logic [CODE_W-1:0] cfg_code,
   input  logic [CODE_W-1:0] cfg_mask,
   input  logic              cfg_single,
   input  logic              cfg_enh,
   output logic              acc_valid,
   output logic              acc_hit
);
   if (ID_W != EXT_ID_W) begin : g_bad_id
      $error("can_accept_filter: ID_W must be 29");
   end
   if (DATA_W != BYTE_W || CODE_W != CFG_W) begin : g_bad_byte
      $error("can_accept_filter: byte layout must be 4 x 8 bits");
   end
   if (LEN_W != DLC_W) begin : g_bad_dlc
      $error("can_accept_filter: LEN_W must be 4");
   end

   frame_t frm;
   assign frm = '{id: frm_id, ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc,
                  d0: frm_data0, d1: frm_data1};

   logic single_hit, dual_hit, decide;

   can_flt_single u_single (
      .frm  (frm),
      .code (cfg_code),
      .mask (cfg_mask),
      .hit  (single_hit)
   );

   can_flt_dual #(.NBANK(CFG_BYTES/2)) u_dual (
      .frm  (frm),
      .code (cfg_code),
      .mask (cfg_mask),
      .hit  (dual_hit)
   );

   always_comb begin
      if (!cfg_enh)       decide = 1'b1;
      else if (cfg_single) decide = single_hit;
      else                 decide = dual_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_hit   <= 1'b0;
      end else begin
         acc_valid <= frm_valid;
         acc_hit   <= frm_valid && decide;
      end
   end

   // R1
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> acc_valid);
   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !acc_valid);
   // R1
   hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !acc_hit);
   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !cfg_enh) |=> acc_hit);
   // R3
   single_ext_dc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && cfg_enh && cfg_single && frm_ext && (&cfg_mask)) |=> acc_hit);
   // R5
   single_rtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && cfg_enh && cfg_single && !frm_ext && frm_rtr
       && (&cfg_mask[2*BYTE_W-1:0])) |=> acc_hit);
   // R7
   dual_ext_dc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && cfg_enh && !cfg_single && frm_ext
       && (&cfg_mask[2*BYTE_W-1:0])) |=> acc_hit);
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;
   localparam int N_RAND     = 800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [28:0] frm_id = '0;
   logic        frm_ext = 1'b0;
   logic        frm_rtr = 1'b0;
   logic [3:0]  frm_dlc = '0;
   logic [7:0]  frm_data0 = '0;
   logic [7:0]  frm_data1 = '0;
   logic [31:0] cfg_code = '0;
   logic [31:0] cfg_mask = '0;
   logic        cfg_single = 1'b0;
   logic        cfg_enh = 1'b0;
   logic        acc_valid, acc_hit;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_accept_filter dut_i (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
      .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
      .frm_data0(frm_data0), .frm_data1(frm_data1), .cfg_code(cfg_code),
      .cfg_mask(cfg_mask), .cfg_single(cfg_single), .cfg_enh(cfg_enh),
      .acc_valid(acc_valid), .acc_hit(acc_hit)
   );

   // byte 0 is the most significant byte of v
   function automatic logic [31:0] bytes_of(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic ok8(input logic [7:0] a, b, m);
      return ((a ^ b) & ~m) == 8'h00;
   endfunction

   function automatic logic ref_accept(
      input logic [28:0] id, input logic ext, rtr, input logic [3:0] dlc,
      input logic [7:0] d0, d1, input logic [31:0] code, mask,
      input logic single, enh);
      logic [7:0] c [4];
      logic [7:0] m [4];
      logic idok, a, b;
      for (int k = 0; k < 4; k++) begin
         c[k] = code[8*k +: 8];
         m[k] = mask[8*k +: 8];
      end
      if (!enh) return 1'b1;
      if (single) begin
         if (ext) begin
            return ok8(id[28:21], c[0], m[0]) && ok8(id[20:13], c[1], m[1]) &&
                   ok8(id[12:5], c[2], m[2]) &&
                   ok8({id[4:0], rtr, 2'b00}, {c[3][7:2], 2'b00}, {m[3][7:2], 2'b11});
         end
         idok = ok8(id[10:3], c[0], m[0]) &&
                ok8({id[2:0], rtr, 4'h0}, {c[1][7:4], 4'h0}, {m[1][7:4], 4'hF});
         if (!idok) return 1'b0;
         if (rtr || dlc == 0) return 1'b1;
         if (!ok8(d0, c[2], m[2])) return 1'b0;
         if (dlc == 1) return 1'b1;
         return ok8(d1, c[3], m[3]);
      end
      if (ext) begin
         a = ok8(id[28:21], c[0], m[0]) && ok8(id[20:13], c[1], m[1]);
         b = ok8(id[28:21], c[2], m[2]) && ok8(id[20:13], c[3], m[3]);
         return a || b;
      end
      a = ok8(id[10:3], c[0], m[0]) &&
          ok8({id[2:0], rtr, 4'h0}, {c[1][7:4], 4'h0}, {m[1][7:4], 4'hF}) &&
          ok8(d0, {c[1][3:0], c[3][3:0]}, {m[1][3:0], m[3][3:0]});
      b = ok8(id[10:3], c[2], m[2]) &&
          ok8({id[2:0], rtr, 4'h0}, {c[3][7:4], 4'h0}, {m[3][7:4], 4'hF});
      return a || b;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [28:0] id, input logic ext, rtr,
                       input logic [3:0] dlc, input logic [7:0] d0, d1,
                       input logic exp, input string tag);
      @(negedge clk);
      frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc;
      frm_data0 = d0; frm_data1 = d1; frm_valid = 1'b1;
      @(negedge clk);
      check(tag, acc_valid, 1'b1, "acc_valid");
      check(tag, acc_hit, exp, "acc_hit");
      frm_valid = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] r;
      logic [28:0] rid;
      logic        rext, rrtr, rsg, ren;
      logic [3:0]  rdlc;
      logic [7:0]  rd0, rd1;
      string       tg;
      r = $urandom(32'd4242);

      // reset state (R1)
      repeat (3) @(negedge clk);
      check("R1", acc_valid, 1'b0, "reset acc_valid");
      check("R1", acc_hit, 1'b0, "reset acc_hit");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", acc_valid, 1'b0, "idle acc_valid");

      // R2: bypass with a config that would reject
      cfg_enh = 1'b0; cfg_single = 1'b1;
      cfg_code = 32'hFFFF_FFFF; cfg_mask = 32'h0;
      send(29'h0000_0001, 1'b1, 1'b0, 4'd3, 8'h00, 8'h00, 1'b1, "R2");
      send(29'h0000_0002, 1'b0, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1, "R2");

      // R3: single filter, extended
      cfg_enh = 1'b1;
      cfg_code = bytes_of({29'h0ABC_DE5, 1'b0, 2'b00});
      send(29'h0ABC_DE5, 1'b1, 1'b0, 4'd8, 8'h11, 8'h22, 1'b1, "R3");
      send(29'h0ABC_DE4, 1'b1, 1'b0, 4'd8, 8'h11, 8'h22, 1'b0, "R3");
      send(29'h1ABC_DE5, 1'b1, 1'b0, 4'd8, 8'h11, 8'h22, 1'b0, "R3");
      send(29'h0ABC_DE5, 1'b1, 1'b1, 4'd0, 8'h11, 8'h22, 1'b0, "R3");
      cfg_mask = 32'h0400_0000;   // mask byte 3 bit 2: rtr don't care
      send(29'h0ABC_DE5, 1'b1, 1'b1, 4'd0, 8'h11, 8'h22, 1'b1, "R3");

      // R4/R5/R6: single filter, standard
      cfg_code = bytes_of({11'h5A3, 1'b0, 4'h0, 8'h3C, 8'hC3});
      cfg_mask = 32'h0;
      send(29'h1FFF_F5A3, 1'b0, 1'b0, 4'd8, 8'h3C, 8'hC3, 1'b1, "R4");
      send(29'h0000_05A2, 1'b0, 1'b0, 4'd8, 8'h3C, 8'hC3, 1'b0, "R4");
      send(29'h0000_05A3, 1'b0, 1'b0, 4'd1, 8'h3D, 8'hC3, 1'b0, "R6");
      send(29'h0000_05A3, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, "R5");
      send(29'h0000_05A3, 1'b0, 1'b0, 4'd1, 8'h3C, 8'h00, 1'b1, "R6");
      send(29'h0000_05A3, 1'b0, 1'b0, 4'd2, 8'h3C, 8'h00, 1'b0, "R6");
      send(29'h0000_05A3, 1'b0, 1'b0, 4'd15, 8'h3C, 8'hC3, 1'b1, "R6");
      cfg_mask = bytes_of(32'h0010_0000);   // code1 bit 4: rtr don't care
      send(29'h0000_05A3, 1'b0, 1'b1, 4'd5, 8'h00, 8'h00, 1'b1, "R5");
      cfg_mask = bytes_of(32'h0000_FF00);   // mask byte 2 all don't care
      send(29'h0000_05A3, 1'b0, 1'b0, 4'd1, 8'h99, 8'h00, 1'b1, "R6");

      // R7: dual filter, extended
      cfg_single = 1'b0; cfg_mask = 32'h0;
      cfg_code = bytes_of({16'hF2D0, 16'h0000});
      send({16'hF2D0, 13'h1FFF}, 1'b1, 1'b1, 4'd2, 8'h00, 8'h00, 1'b1, "R7");
      send({16'h0000, 13'h0ABC}, 1'b1, 1'b0, 4'd2, 8'h00, 8'h00, 1'b1, "R7");
      send({16'h5555, 13'h0000}, 1'b1, 1'b0, 4'd2, 8'h00, 8'h00, 1'b0, "R7");

      // R8/R9: dual filter, standard
      cfg_code = bytes_of({11'h2F1, 1'b0, 4'hA, 11'h0C4, 1'b0, 4'h5});
      send(29'h0000_02F1, 1'b0, 1'b0, 4'd0, 8'hA5, 8'h00, 1'b1, "R8");
      send(29'h0000_02F1, 1'b0, 1'b0, 4'd0, 8'hA4, 8'h00, 1'b0, "R8");
      send(29'h0000_02F1, 1'b0, 1'b1, 4'd1, 8'hA5, 8'h00, 1'b0, "R8");
      send(29'h0000_00C4, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, "R9");
      send(29'h0000_00C4, 1'b0, 1'b1, 4'd0, 8'h00, 8'h00, 1'b0, "R9");
      send(29'h0000_03FF, 1'b0, 1'b0, 4'd3, 8'hA5, 8'h00, 1'b0, "R9");

      // R1: idle cycle after traffic
      @(negedge clk);
      check("R1", acc_valid, 1'b0, "idle after frames");
      check("R1", acc_hit, 1'b0, "idle hit");

      // random mix
      for (int n = 0; n < N_RAND; n++) begin
         ren  = ($urandom % 8) != 0;
         rsg  = $urandom % 2;
         rext = $urandom % 2;
         rrtr = ($urandom % 4) == 0;
         rdlc = 4'($urandom % 11);
         cfg_code = $urandom;
         cfg_mask = $urandom | $urandom | $urandom;
         rid = 29'($urandom);
         rd0 = 8'($urandom);
         rd1 = 8'($urandom);
         if ($urandom % 2) begin
            if (rext) rid = {cfg_code[7:0], cfg_code[15:8], cfg_code[23:16], cfg_code[31:27]};
            else      rid = {18'h0, cfg_code[7:0], cfg_code[15:13]};
            rd0 = rsg ? cfg_code[23:16] : {cfg_code[11:8], cfg_code[27:24]};
            rd1 = cfg_code[31:24];
         end
         cfg_enh = ren; cfg_single = rsg;
         if (!ren)      tg = "R2";
         else if (rsg)  tg = rext ? "R3" : "R6";
         else           tg = rext ? "R7" : "R9";
         send(rid, rext, rrtr, rdlc, rd0, rd1,
              ref_accept(rid, rext, rrtr, rdlc, rd0, rd1, cfg_code, cfg_mask, rsg, ren), tg);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule